// File: doc/BRIEF.md
# Nine-Bit Framed Serial Display Receiver

This block is the receive end of a one-way, three-wire serial link that a host uses to feed a display controller. The host pulls an active-low select line low and clocks in frames on a data line. Each frame is nine bits long. The first bit says whether the byte that follows is a command or display-memory data. The eight byte bits follow, most significant first. Frames may follow one another with no gap for as long as the select line stays low.

All three serial lines are brought into the system clock domain through two-flop synchronizers, and serial clock edges are found by comparing successive samples. The system clock must run at least four times faster than the serial clock. Each finished frame gives one single-cycle strobe. A command frame raises the command strobe, with its byte. A data frame raises the memory-write strobe, with its byte and a 10-bit address. That address then steps by one and wraps to zero after its maximum. Raising select partway through a frame drops the partial frame. A synchronous reset aborts any frame and clears the address.

Top module: `serial_disp_rx`

## Requirements
- R1: A frame whose first bit is 0 produces exactly one command strobe (`cmd_vld`) carrying its byte, and no write strobe.
- R2: A frame whose first bit is 1 produces exactly one write strobe (`wr_vld`) carrying its byte on `wr_byte` and the current address on `wr_addr`.
- R3: The eight byte bits arrive most significant bit first; the bit sampled on the second rising serial clock edge of a frame lands in bit 7.
- R4: The address steps by one after every data frame and is left unchanged by command frames.
- R5: The address is 10 bits wide and wraps from 1023 to 0.
- R6: While select stays low, the rising edge after a frame's last bit is taken as the type bit of the next frame, with no gap needed.
- R7: Serial clock edges seen while select is high have no effect and produce no strobe.
- R8: If select rises before a frame is complete, the partial frame gives no strobe, and the next rising edge after select falls again is a type bit.
- R9: Reset aborts a frame in progress, clears the address to 0 and holds both strobes low. If select is low when reset ends, the next rising edge is a type bit.
- R10: Each strobe lasts one system clock cycle, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_dat | input | 1 | Serial data input |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte, valid with cmd_vld |
| wr_vld | output | 1 | One-cycle display-memory write strobe |
| wr_byte | output | 8 | Data byte, valid with wr_vld |
| wr_addr | output | 10 | Write address in use before the step, valid with wr_vld |

## Verification
The hardest case to reach from the ports is the address wrap. The address counter is not visible until a write happens, so the stimulus streams 1025 data frames back to back under one low select. It then checks the last write before the wrap and the first write after it. Two other cases need care: a partial frame cut off by select, and a reset arriving mid-frame. For each, the bench sends a few bits, breaks the frame, and then shows through one complete frame that the bit position and the address came back to their initial states.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    KIND_CMD  = 1'b0,
    KIND_DATA = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/disp_rx_sync.sv
module disp_rx_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic stage1, stage2;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= RST_VAL[g];
          stage2 <= RST_VAL[g];
        end else begin
          stage1 <= d_async[g];
          stage2 <= stage1;
        end
      end
      assign d_sync[g] = stage2;
    end
  endgenerate
endmodule

// File: rtl/disp_rx_framer.sv
module disp_rx_framer
  import disp_rx_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_act,
  input  logic            bit_stb,
  input  logic            bit_val,
  output logic            frame_done,
  output frame_kind_e     frame_kind,
  output logic [BITS-1:0] frame_byte
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

  logic [CNT_W-1:0] pos;
  logic [BITS-1:0]  shreg;
  frame_kind_e      kind_q;

  always_ff @(posedge clk) begin
    frame_done <= 1'b0;
    if (rst) begin
      pos    <= '0;
      shreg  <= '0;
      kind_q <= KIND_CMD;
    end else if (!sel_act) begin
      pos <= '0;
    end else if (bit_stb) begin
      if (pos == '0) begin
        kind_q <= frame_kind_e'(bit_val);
        pos    <= CNT_W'(1);
      end else begin
        shreg <= {shreg[BITS-2:0], bit_val};
        if (pos == LAST) begin
          pos        <= '0;
          frame_done <= 1'b1;
        end else begin
          pos <= pos + CNT_W'(1);
        end
      end
    end
  end

  assign frame_kind = kind_q;
  assign frame_byte = shreg;
endmodule

// File: rtl/disp_rx_addr.sv
module disp_rx_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= addr + ADDR_W'(1);
  end
endmodule

// File: rtl/serial_disp_rx.sv
module serial_disp_rx
  import disp_rx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              cmd_vld,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              wr_vld,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [ADDR_W-1:0] wr_addr
);
  // synchronized lines: {sel_n, sclk, dat}
  logic [2:0] raw_lines, syn_lines;
  logic       sel_n_s, sclk_s, dat_s, sclk_q, rise;

  assign raw_lines = {ser_sel_n, ser_clk, ser_dat};

  disp_rx_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_lines),
    .d_sync  (syn_lines)
  );

  assign {sel_n_s, sclk_s, dat_s} = syn_lines;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_q & ~sel_n_s;

  logic              done;
  frame_kind_e       kind;
  logic [BYTE_W-1:0] byte_v;

  disp_rx_framer #(.BITS(BYTE_W)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .sel_act    (~sel_n_s),
    .bit_stb    (rise),
    .bit_val    (dat_s),
    .frame_done (done),
    .frame_kind (kind),
    .frame_byte (byte_v)
  );

  logic              data_done;
  logic [ADDR_W-1:0] addr_cur;

  assign data_done = done && (kind == KIND_DATA);

  disp_rx_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .step (data_done),
    .addr (addr_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld  <= 1'b0;
      wr_vld   <= 1'b0;
      cmd_byte <= '0;
      wr_byte  <= '0;
      wr_addr  <= '0;
    end else begin
      cmd_vld <= done && (kind == KIND_CMD);
      wr_vld  <= data_done;
      if (done && kind == KIND_CMD) cmd_byte <= byte_v;
      if (data_done) begin
        wr_byte <= byte_v;
        wr_addr <= addr_cur;
      end
    end
  end
endmodule

// File: rtl/disp_rx_checker.sv
module disp_rx_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_sel_n,
  input logic              cmd_vld,
  input logic              wr_vld,
  input logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] last_addr;
  logic              seen_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr   <= 1'b0;
      last_addr <= '0;
    end else if (wr_vld) begin
      seen_wr   <= 1'b1;
      last_addr <= wr_addr;
    end
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_vld && wr_vld));

  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> !cmd_vld);

  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> !wr_vld);

  // R4 and R5: consecutive writes use consecutive addresses, wrapping
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && seen_wr) |-> (wr_addr == ADDR_W'(last_addr + ADDR_W'(1))));

  assert_addr_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && !seen_wr) |-> (wr_addr == '0));

  assert_strobes_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_vld && !wr_vld));

  assert_idle_sel_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ser_sel_n, 3) |-> (!cmd_vld && !wr_vld));
endmodule

bind serial_disp_rx disp_rx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_sel_n (ser_sel_n),
  .cmd_vld   (cmd_vld),
  .wr_vld    (wr_vld),
  .wr_addr   (wr_addr)
);

// File: tb/test_serial_disp_rx.sv
module test_serial_disp_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial half period
  localparam int AW         = 10;

  typedef struct packed {
    logic       flag;
    logic [7:0] val;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA5}, '{1'b0, 8'h80}, '{1'b1, 8'h01}, '{1'b1, 8'hFF},
    '{1'b0, 8'h3C}, '{1'b0, 8'h00}, '{1'b1, 8'h5A}, '{1'b1, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
  logic          cmd_vld, wr_vld;
  logic [7:0]    cmd_byte, wr_byte;
  logic [AW-1:0] wr_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_disp_rx #(.ADDR_W(AW)) i_serial_disp_rx (
    .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .wr_vld(wr_vld), .wr_byte(wr_byte), .wr_addr(wr_addr)
  );

  int n_checks = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_both = 0;
  logic [7:0]    last_cmd = '0, last_wb = '0;
  logic [AW-1:0] last_wa = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_vld) begin n_cmd++; last_cmd = cmd_byte; end
      if (wr_vld)  begin n_wr++;  last_wb = wr_byte; last_wa = wr_addr; end
      if (cmd_vld && wr_vld) n_both++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_clk = 1'b0;
    ser_dat = b;
    wait_clk(HALF);
    ser_clk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_frame(input logic flag, input logic [7:0] v);
    send_bit(flag);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic select_low();
    @(negedge clk);
    ser_clk = 1'b0;
    wait_clk(HALF);
    ser_sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic select_high();
    @(negedge clk);
    ser_clk = 1'b0;
    wait_clk(2);
    ser_sel_n = 1'b1;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int exp_addr;
    int c0, w0;
    wait_clk(6);
    // R9: strobes low while reset is held
    chk(!cmd_vld && !wr_vld, "R9 reset strobes", {cmd_vld, wr_vld}, 0);
    @(negedge clk) rst = 1'b0;
    wait_clk(4);

    // Table walk, frames back to back under one low select (R1-R4, R6)
    exp_addr = 0;
    select_low();
    for (int k = 0; k < NV; k++) begin
      c0 = n_cmd; w0 = n_wr;
      send_frame(VEC[k].flag, VEC[k].val);
      wait_clk(6);
      if (VEC[k].flag) begin
        chk(n_wr == w0 + 1 && n_cmd == c0, "R2 R6 one write strobe", n_wr - w0, 1);
        chk(last_wb == VEC[k].val, "R2 R3 write byte", last_wb, VEC[k].val);
        chk(last_wa == AW'(exp_addr), "R4 write address", last_wa, exp_addr);
        exp_addr++;
      end else begin
        chk(n_cmd == c0 + 1 && n_wr == w0, "R1 R6 one command strobe", n_cmd - c0, 1);
        chk(last_cmd == VEC[k].val, "R1 R3 command byte", last_cmd, VEC[k].val);
      end
    end
    chk(n_both == 0, "R10 strobes exclusive", n_both, 0);

    // R7: clock edges with select high do nothing
    select_high();
    c0 = n_cmd; w0 = n_wr;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    wait_clk(6);
    chk(n_cmd == c0 && n_wr == w0, "R7 no strobe while deselected",
        (n_cmd - c0) + (n_wr - w0), 0);
    select_low();
    send_frame(1'b0, 8'h42);
    wait_clk(6);
    chk(n_cmd == c0 + 1 && last_cmd == 8'h42, "R7 frame after idle clocks", last_cmd, 8'h42);

    // R8: partial frame dropped when select rises
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    select_high();
    select_low();
    c0 = n_cmd; w0 = n_wr;
    send_frame(1'b0, 8'h99);
    wait_clk(6);
    chk(n_cmd == c0 + 1 && n_wr == w0, "R8 only the full frame strobes",
        n_cmd - c0, 1);
    chk(last_cmd == 8'h99, "R8 byte aligned after abort", last_cmd, 8'h99);
    send_frame(1'b1, 8'hC3);
    wait_clk(6);
    chk(last_wa == AW'(exp_addr), "R8 R4 address kept after abort", last_wa, exp_addr);

    // R9: reset mid-frame with select kept low
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    @(negedge clk) rst = 1'b1;
    wait_clk(3);
    chk(!cmd_vld && !wr_vld, "R9 strobes low in reset", {cmd_vld, wr_vld}, 0);
    @(negedge clk) rst = 1'b0;
    ser_clk = 1'b0;
    wait_clk(6);
    w0 = n_wr;
    send_frame(1'b1, 8'h3C);
    wait_clk(6);
    chk(n_wr == w0 + 1 && last_wb == 8'h3C, "R9 frame after reset", last_wb, 8'h3C);
    chk(last_wa == '0, "R9 address cleared", last_wa, 0);

    // R5: address wrap over a long stream of data frames
    exp_addr = 1;
    for (int i = 1; i <= 1024; i++) begin
      send_frame(1'b1, 8'(i));
      if (i == 1022) begin
        wait_clk(6);
        chk(last_wa == AW'(1022), "R5 address before wrap", last_wa, 1022);
      end
    end
    wait_clk(6);
    chk(last_wa == AW'(0) && last_wb == 8'(1024), "R5 address wraps to zero", last_wa, 0);
    chk(n_both == 0, "R10 strobes never overlap", n_both, 0);

    select_high();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule